// File: doc/BRIEF.md
# Serial EEPROM Command Slave (three-wire, x8/x16)

This block is the command side of a serial EEPROM that sits on a three-wire synchronous link: a select line, a serial clock and a serial data input, with a serial data output that has its own drive enable. A host raises the select line and clocks in a start bit, then a two-bit operation code, then an address, and for write-type operations a data word. The block carries out reads, single-word writes and erases, whole-array writes and erases, and the commands that open or close the write latch. The array is a register file inside the block. All line sampling is done with the system clock, and the edges of the serial clock are found by comparing two samples.

A mode input picks 16-bit words (fewer address bits) or 8-bit words (one more address bit). Programming takes a fixed number of system clocks, set by a parameter. While programming runs, a host that raises the select line sees the data output low. The output goes high when the work is done. A separate allow input, when low, blocks every change to the array. Reads send a zero bit first and then the word, most significant bit first. The address keeps counting up for as long as the serial clock keeps running.

Top module: `eew_slave`

## Requirements
- R1: A command begins only at the first rising serial-clock edge where select and data-in are both high. Zero bits and clock pulses before that edge, and any activity while select is low, start nothing.
- R2: After the start bit come two operation bits, sent MSB first: 10 reads, 01 writes one word, 11 erases one word. With 00, the two most significant address bits choose the action: 11 opens the write latch, 00 closes it, 10 erases the whole array, 01 writes one data word to every location.
- R3: With wide_mode high, words are 16 bits wide and addresses are 6 bits. With it low, words are 8 bits and addresses are 7 bits. A 16-bit word n is made of byte 2n (low half) and byte 2n+1 (high half).
- R4: After reset the write latch is closed. While it is closed, single and whole-array writes and erases change nothing and start no programming. The latch opens with the open command and closes with the close command.
- R5: When select falls before every bit an operation needs has been clocked in, the operation is dropped and the array is left unchanged.
- R6: ser_out_en is low after reset, and it is low whenever select has been low for two system clocks. It is high only while read bits are sent or while programming status is shown.
- R7: Once a change has been accepted, the array is busy for BUSY_CYCLES system clocks. If select is raised during that time, ser_out shows 0 with ser_out_en high. Once the work is done it shows 1.
- R8: A read first drives one 0 bit, after the last address bit. Each later rising serial-clock edge then drives the next data bit, MSB first.
- R9: If the serial clock keeps running after a word has been read, the next word follows, at the address plus one. The address wraps from the last location to zero.
- R10: When wr_allow is low, no write or erase of any kind changes the array or starts programming.
- R11: An erased location reads as all ones, and so does every location after reset. Whole-array erase sets every location to all ones. Whole-array write puts the given word in every location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel | input | 1 | Select line, high while a host talks to the device |
| ser_clk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial data in, sampled on rising serial-clock edges |
| wide_mode | input | 1 | High selects 16-bit words, low selects 8-bit words |
| wr_allow | input | 1 | Low blocks every array change |
| ser_out | output | 1 | Serial data out: read data or ready status |
| ser_out_en | output | 1 | Drive enable for ser_out; low means high-impedance |

## Verification
The assertions assume a few things about the host. Data-in is stable whenever a rising serial-clock edge is sampled. Every serial-clock phase lasts several system clocks. wide_mode holds steady for the whole of a command. The bench drives every serial half-period as four system clocks. It changes data-in only while the serial clock is low. It changes select only with the serial clock low, and it changes the mode input only between commands. The bench therefore never steps outside what the assertions take for granted.

// File: rtl/eew_pkg.sv
package eew_pkg;
    // Array geometry: x16 word address width; x8 adds one bit.
    localparam int unsigned WADDR_W = 6;
    localparam int unsigned BADDR_W = WADDR_W + 1;
    localparam int unsigned NBYTES  = 1 << BADDR_W;
    localparam int unsigned CNT_W   = 5;

    typedef logic [BADDR_W-1:0] baddr_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_HOLD
    } cmd_state_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_WRITE, OP_ERASE, OP_WRAL, OP_ERAL
    } prog_op_e;

    typedef struct packed {
        prog_op_e    op;
        logic        wide;
        baddr_t      addr;
        logic [15:0] data;
    } prog_req_t;

    function automatic logic [CNT_W-1:0] addr_len(input logic wide);
        return wide ? CNT_W'(WADDR_W) : CNT_W'(BADDR_W);
    endfunction

    function automatic logic [CNT_W-1:0] data_len(input logic wide);
        return wide ? CNT_W'(16) : CNT_W'(8);
    endfunction

    function automatic baddr_t addr_next(input baddr_t a, input logic wide);
        baddr_t n;
        n = a + baddr_t'(1);
        if (wide) n[BADDR_W-1] = 1'b0;
        return n;
    endfunction
endpackage

// File: rtl/eew_pinsamp.sv
module eew_pinsamp (
    input  logic clk,
    input  logic rst,
    input  logic chip_sel,
    input  logic ser_clk,
    input  logic ser_in,
    input  logic wide_mode,
    input  logic wr_allow,
    output logic cs_q,
    output logic di_q,
    output logic wide_q,
    output logic allow_q,
    output logic sck_rise
);
    logic sck_q, sck_qq;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= 1'b0;
            di_q    <= 1'b0;
            wide_q  <= 1'b0;
            allow_q <= 1'b0;
            sck_q   <= 1'b0;
            sck_qq  <= 1'b0;
        end else begin
            cs_q    <= chip_sel;
            di_q    <= ser_in;
            wide_q  <= wide_mode;
            allow_q <= wr_allow;
            sck_q   <= ser_clk;
            sck_qq  <= sck_q;
        end
    end

    assign sck_rise = sck_q & ~sck_qq;
endmodule

// File: rtl/eew_array.sv
module eew_array
    import eew_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        prog_go,
    input  prog_req_t   prog_req,
    input  baddr_t      rd_addr,
    input  logic        rd_wide,
    output logic [15:0] rd_word,
    output logic        busy
);
    localparam int unsigned TMR_W = $clog2(BUSY_CYCLES + 1);

    logic [7:0]       mem [NBYTES];
    logic [TMR_W-1:0] tmr;
    prog_req_t        req_l;
    logic [15:0]      val;
    logic             done;

    assign val  = (req_l.op == OP_ERASE || req_l.op == OP_ERAL) ? 16'hFFFF : req_l.data;
    assign done = busy && (tmr == TMR_W'(BUSY_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            tmr   <= '0;
            req_l <= '0;
            for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
        end else if (prog_go && !busy) begin
            busy  <= 1'b1;
            tmr   <= '0;
            req_l <= prog_req;
        end else if (busy) begin
            tmr <= tmr + TMR_W'(1);
            if (done) begin
                busy <= 1'b0;
                case (req_l.op)
                    OP_WRITE, OP_ERASE: begin
                        if (req_l.wide) begin
                            mem[{req_l.addr[WADDR_W-1:0], 1'b0}] <= val[7:0];
                            mem[{req_l.addr[WADDR_W-1:0], 1'b1}] <= val[15:8];
                        end else begin
                            mem[req_l.addr] <= val[7:0];
                        end
                    end
                    OP_WRAL, OP_ERAL: begin
                        for (int i = 0; i < NBYTES; i++)
                            mem[i] <= (req_l.wide && i[0]) ? val[15:8] : val[7:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        if (rd_wide)
            rd_word = {mem[{rd_addr[WADDR_W-1:0], 1'b1}], mem[{rd_addr[WADDR_W-1:0], 1'b0}]};
        else
            rd_word = {mem[rd_addr], 8'h00};
    end

    // A new change is never handed over while one is in flight.
    assert_go_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        prog_go |-> !busy);
    // Busy window never outlasts the programmed count.
    assert_busy_bound_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tmr < TMR_W'(BUSY_CYCLES)));
endmodule

// File: rtl/eew_cmd.sv
module eew_cmd
    import eew_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_q,
    input  logic        di_q,
    input  logic        sck_rise,
    input  logic        wide_q,
    input  logic        allow_q,
    input  logic        busy,
    input  logic [15:0] rd_word,
    output baddr_t      rd_addr,
    output logic        rd_wide,
    output logic        prog_go,
    output prog_req_t   prog_req,
    output logic        ser_out,
    output logic        ser_out_en
);
    cmd_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       opc;
    baddr_t           addr;
    logic [15:0]      dat, sh;
    logic             wen, stat_pend, do_r, wide_l;

    baddr_t      nxt_addr;
    logic [15:0] nxt_dat;
    logic [1:0]  top2;
    logic        may_prog;

    assign nxt_addr = {addr[BADDR_W-2:0], di_q};
    assign nxt_dat  = {dat[14:0], di_q};
    assign top2     = wide_l ? nxt_addr[WADDR_W-1 -: 2] : nxt_addr[BADDR_W-1 -: 2];
    assign may_prog = wen && allow_q;
    assign rd_addr  = (st == ST_ADDR) ? nxt_addr : addr_next(addr, wide_l);
    assign rd_wide  = wide_l;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            opc       <= '0;
            addr      <= '0;
            dat       <= '0;
            sh        <= '0;
            wen       <= 1'b0;
            stat_pend <= 1'b0;
            do_r      <= 1'b0;
            wide_l    <= 1'b0;
            prog_go   <= 1'b0;
            prog_req  <= '0;
        end else begin
            prog_go <= 1'b0;
            if (!cs_q) begin
                st <= ST_IDLE;
            end else if (sck_rise) begin
                case (st)
                    ST_IDLE: if (di_q && !busy) begin
                        st        <= ST_OPC;
                        cnt       <= '0;
                        stat_pend <= 1'b0;
                        wide_l    <= wide_q;
                    end
                    ST_OPC: begin
                        opc <= {opc[0], di_q};
                        cnt <= cnt + CNT_W'(1);
                        if (cnt == CNT_W'(1)) begin
                            st   <= ST_ADDR;
                            cnt  <= '0;
                            addr <= '0;
                        end
                    end
                    ST_ADDR: begin
                        addr <= nxt_addr;
                        cnt  <= cnt + CNT_W'(1);
                        if (cnt == addr_len(wide_l) - CNT_W'(1)) begin
                            cnt <= '0;
                            dat <= '0;
                            st  <= ST_HOLD;
                            case (opc)
                                2'b10: begin
                                    st   <= ST_READ;
                                    do_r <= 1'b0;
                                    sh   <= rd_word;
                                    cnt  <= data_len(wide_l);
                                end
                                2'b01: st <= ST_DATA;
                                2'b11: if (may_prog) begin
                                    prog_go   <= 1'b1;
                                    stat_pend <= 1'b1;
                                    prog_req  <= '{op: OP_ERASE, wide: wide_l, addr: nxt_addr, data: 16'hFFFF};
                                end
                                default: case (top2)
                                    2'b11: wen <= 1'b1;
                                    2'b00: wen <= 1'b0;
                                    2'b01: st  <= ST_DATA;
                                    default: if (may_prog) begin
                                        prog_go   <= 1'b1;
                                        stat_pend <= 1'b1;
                                        prog_req  <= '{op: OP_ERAL, wide: wide_l, addr: '0, data: 16'hFFFF};
                                    end
                                endcase
                            endcase
                        end
                    end
                    ST_DATA: begin
                        dat <= nxt_dat;
                        cnt <= cnt + CNT_W'(1);
                        if (cnt == data_len(wide_l) - CNT_W'(1)) begin
                            st <= ST_HOLD;
                            if (may_prog) begin
                                prog_go   <= 1'b1;
                                stat_pend <= 1'b1;
                                prog_req  <= '{op: (opc == 2'b01) ? OP_WRITE : OP_WRAL,
                                               wide: wide_l, addr: addr, data: nxt_dat};
                            end
                        end
                    end
                    ST_READ: begin
                        if (cnt == '0) begin
                            do_r <= rd_word[15];
                            sh   <= {rd_word[14:0], 1'b0};
                            cnt  <= data_len(wide_l) - CNT_W'(1);
                            addr <= addr_next(addr, wide_l);
                        end else begin
                            do_r <= sh[15];
                            sh   <= {sh[14:0], 1'b0};
                            cnt  <= cnt - CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ser_out_en = cs_q && ((st == ST_READ) ||
                        (stat_pend && (st == ST_IDLE || st == ST_HOLD)));
    assign ser_out    = (st == ST_READ) ? do_r : !busy;

    // Any array change needs the open write latch.
    assert_prog_needs_wen_R4: assert property (@(posedge clk) disable iff (rst)
        prog_go |-> wen);
    // Any array change needs the allow input high.
    assert_prog_needs_allow_R10: assert property (@(posedge clk) disable iff (rst)
        prog_go |-> allow_q);
    // The first bit after the address is the leading zero.
    assert_dummy_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READ && $past(st) == ST_ADDR) |-> !do_r);
    // Leaving idle needs a sampled edge with select and data-in high.
    assert_start_bit_R1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPC && $past(st) == ST_IDLE) |-> $past(sck_rise && di_q && cs_q));
endmodule

// File: rtl/eew_slave.sv
module eew_slave
    import eew_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic chip_sel,
    input  logic ser_clk,
    input  logic ser_in,
    input  logic wide_mode,
    input  logic wr_allow,
    output logic ser_out,
    output logic ser_out_en
);
    logic        cs_q, di_q, wide_q, allow_q, sck_rise;
    logic        busy, prog_go, rd_wide;
    logic [15:0] rd_word;
    baddr_t      rd_addr;
    prog_req_t   prog_req;

    eew_pinsamp u_pins (
        .clk(clk), .rst(rst), .chip_sel(chip_sel), .ser_clk(ser_clk),
        .ser_in(ser_in), .wide_mode(wide_mode), .wr_allow(wr_allow),
        .cs_q(cs_q), .di_q(di_q), .wide_q(wide_q), .allow_q(allow_q),
        .sck_rise(sck_rise)
    );

    eew_cmd u_cmd (
        .clk(clk), .rst(rst), .cs_q(cs_q), .di_q(di_q), .sck_rise(sck_rise),
        .wide_q(wide_q), .allow_q(allow_q), .busy(busy), .rd_word(rd_word),
        .rd_addr(rd_addr), .rd_wide(rd_wide), .prog_go(prog_go),
        .prog_req(prog_req), .ser_out(ser_out), .ser_out_en(ser_out_en)
    );

    eew_array #(.BUSY_CYCLES(BUSY_CYCLES)) u_array (
        .clk(clk), .rst(rst), .prog_go(prog_go), .prog_req(prog_req),
        .rd_addr(rd_addr), .rd_wide(rd_wide), .rd_word(rd_word), .busy(busy)
    );

    // Output drive stops once select has been low for a full sample.
    assert_hiz_after_deselect_R6: assert property (@(posedge clk) disable iff (rst)
        (!cs_q && $past(!cs_q)) |-> !ser_out_en);
endmodule

// File: tb/eew_slave_bench.sv
module eew_slave_bench;
    localparam int BUSY = 40;

    logic clk = 1'b0, rst = 1'b1;
    logic chip_sel = 1'b0, ser_clk = 1'b0, ser_in = 1'b0;
    logic wide_mode = 1'b1, wr_allow = 1'b1;
    logic ser_out, ser_out_en;

    int n_chk = 0, n_fail = 0, cs_low = 0;
    logic [7:0] m [128];
    logic       wen_m = 1'b0;

    always #5 clk = ~clk;

    eew_slave #(.BUSY_CYCLES(BUSY)) u_eew_slave (
        .clk(clk), .rst(rst), .chip_sel(chip_sel), .ser_clk(ser_clk),
        .ser_in(ser_in), .wide_mode(wide_mode), .wr_allow(wr_allow),
        .ser_out(ser_out), .ser_out_en(ser_out_en)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R6 every clock: select low for two clocks means no drive.
    always @(negedge clk) begin
        if (rst) cs_low = 0;
        else begin
            if (cs_low >= 2) chk(ser_out_en === 1'b0, "R6 hiz while deselected", ser_out_en, 0);
            cs_low = chip_sel ? 0 : cs_low + 1;
        end
    end

    initial begin
        #1ms;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        ser_in = b; idle(1);
        ser_clk = 1'b1; idle(4);
        ser_clk = 1'b0; idle(3);
    endtask

    task automatic send(input int v, input int n);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic begin_cmd(input int zeros);
        chip_sel = 1'b1; idle(4);
        send(0, zeros);
        bit_out(1'b1);
    endtask

    task automatic end_cmd();
        chip_sel = 1'b0; ser_in = 1'b0; idle(6);
    endtask

    function automatic int alen(); return wide_mode ? 6 : 7; endfunction
    function automatic int dlen(); return wide_mode ? 16 : 8; endfunction
    function automatic int amax(); return wide_mode ? 64 : 128; endfunction

    function automatic int mword(input int a);
        return wide_mode ? {m[2*a+1], m[2*a]} : int'(m[a]);
    endfunction

    task automatic mset(input int a, input int v);
        if (wide_mode) begin m[2*a] = v[7:0]; m[2*a+1] = v[15:8]; end
        else m[a] = v[7:0];
    endtask

    // Status poll: busy shown low then ready, or no drive if nothing started.
    task automatic poll(input logic started, input string req);
        int t;
        chip_sel = 1'b1; idle(3);
        if (!started) chk(ser_out_en === 1'b0, req, ser_out_en, 0);
        else begin
            chk(ser_out_en === 1'b1 && ser_out === 1'b0, "R7 busy shows low", {ser_out_en, ser_out}, 2);
            t = 0;
            while (ser_out !== 1'b1 && t < BUSY + 20) begin idle(1); t++; end
            chk(ser_out === 1'b1 && ser_out_en === 1'b1, "R7 ready shows high", {ser_out_en, ser_out}, 3);
        end
        end_cmd();
    endtask

    task automatic rd(input int a, input int nwords, input int zeros, input string req);
        int got;
        begin_cmd(zeros);
        send(2, 2); send(a, alen());
        chk(ser_out_en === 1'b1 && ser_out === 1'b0, "R8 leading zero", {ser_out_en, ser_out}, 2);
        for (int w = 0; w < nwords; w++) begin
            got = 0;
            for (int b = 0; b < dlen(); b++) begin
                bit_out(1'b0);
                got = (got << 1) | int'(ser_out === 1'b1);
            end
            chk(got == mword((a + w) % amax()), req, got, mword((a + w) % amax()));
        end
        end_cmd();
    endtask

    task automatic special(input int code);
        begin_cmd(0);
        send(0, 2); send(code << (alen() - 2), alen());
    endtask

    task automatic wr(input int a, input int d, input string req);
        logic go;
        go = wen_m && wr_allow;
        begin_cmd(0); send(1, 2); send(a, alen()); send(d, dlen()); end_cmd();
        if (go) mset(a, d);
        poll(go, req);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) m[i] = 8'hFF;
        idle(5); rst = 1'b0; idle(2);
        chk(ser_out_en === 1'b0, "R6 reset no drive", ser_out_en, 0);

        rd(5, 1, 0, "R11 reset reads ones");
        wr(3, 16'h1234, "R4 latch closed ignores write");
        rd(3, 1, 0, "R4 word unchanged");

        special(3); end_cmd(); wen_m = 1'b1;
        wr(3, 16'hA5C3, "R7 status");
        rd(3, 1, 0, "R3 x16 write readback");

        wide_mode = 1'b0; idle(2);
        wr(9, 8'h3C, "R7 status x8");
        rd(9, 1, 0, "R3 x8 readback");
        rd(6, 2, 0, "R3 x8 bytes of x16 word");
        wide_mode = 1'b1; idle(2);
        rd(4, 1, 0, "R3 x16 word from x8 byte");

        wide_mode = 1'b0; idle(2);
        wr(127, 8'h81, "R7 status");
        rd(126, 4, 0, "R9 x8 sequential wrap");
        wide_mode = 1'b1; idle(2);
        rd(62, 3, 0, "R9 x16 sequential wrap");

        wr_allow = 1'b0;
        wr(3, 16'h0F0F, "R10 allow low no status");
        rd(3, 1, 0, "R10 word unchanged");
        wr_allow = 1'b1;

        begin_cmd(0); send(1, 2); send(3, 6); send(16'h00FF >> 4, 12); end_cmd();
        poll(1'b0, "R5 dropped write no status");
        rd(3, 1, 0, "R5 word unchanged");

        begin_cmd(0); send(3, 2); send(3, 6); end_cmd();
        mset(3, 16'hFFFF); poll(1'b1, "R11 erase");
        rd(3, 1, 0, "R11 erased word ones");

        wide_mode = 1'b0; idle(2);
        special(1); send(8'h5A, 8); end_cmd();
        for (int i = 0; i < 128; i++) m[i] = 8'h5A;
        poll(1'b1, "R2 whole write");
        rd(20, 2, 0, "R11 whole write content");
        wide_mode = 1'b1; idle(2);
        special(2); end_cmd();
        for (int i = 0; i < 128; i++) m[i] = 8'hFF;
        poll(1'b1, "R2 whole erase");
        rd(40, 1, 0, "R11 whole erase content");

        wr(8, 16'hBEEF, "R7 status");
        special(0); end_cmd(); wen_m = 1'b0;
        begin_cmd(0); send(3, 2); send(8, 6); end_cmd();
        poll(1'b0, "R4 erase after close ignored");
        rd(8, 1, 0, "R4 word kept after close");

        chip_sel = 1'b0; ser_in = 1'b1;
        for (int i = 0; i < 3; i++) begin ser_clk = 1'b1; idle(4); ser_clk = 1'b0; idle(4); end
        ser_in = 1'b0;
        rd(8, 1, 3, "R1 leading zeros and deselected pulses");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule